// File: doc/BRIEF.md
# I2C Slave Address and General-Call Decoder

This block is the slave-side front end of a two-wire serial bus port. It watches the sampled clock and data lines and detects start, repeated-start and stop conditions. It decodes the address phase that follows each start and decides whether this device is being addressed. Three kinds of address can match: a 7-bit address, a 10-bit address sent as a reserved prefix byte followed by a low byte, and the all-zero general-call address.

The block answers on the bus through two open-drain pull-down requests, one for data and one for clock. It acknowledges the bytes it accepts and leaves the bus released for the bytes it refuses. When the local logic is not ready, it holds the clock low after the eighth bit. Toward the local logic it pulses a report when an address matches, giving the kind of match and the direction. It also decodes the general-call command byte. For write transfers it hands over one received byte at a time. For read transfers it takes one transmit byte at a time.

Top module: `i2c_addr_decoder`

## Requirements
- R1: During and right after reset, `scl_hold`, `sda_pull` and all report pulses (`hit_valid`, `gc_valid`, `rx_valid`, `tx_taken`) are 0.
- R2: A first byte whose upper 7 bits equal `own_addr7` (with `en_7bit` set) is acknowledged. `hit_valid` pulses with `hit_kind`=1 and `hit_rw` equal to the byte's bit 0 (1 = read).
- R3: A first byte that matches nothing is not acknowledged and produces no report. Every later byte is also ignored (never acknowledged) until the next start condition.
- R4: A first byte 11110xy0 with xy equal to `own_addr10[9:8]` (and `en_10bit` set) is acknowledged without a report. A following byte equal to `own_addr10[7:0]` is acknowledged with `hit_kind`=2 and `hit_rw`=0. A different following byte, or a first byte with other xy, is not acknowledged.
- R5: A first byte 11110xy1 is acknowledged as a 10-bit read (`hit_kind`=2, `hit_rw`=1) only if a full 10-bit write match happened earlier in the same transfer, before the repeated start. After a stop it is refused.
- R6: The first byte 0x00 is acknowledged, with `hit_kind`=3, only when `gc_enable` is 1. Otherwise it is refused. The first byte 0x01 is always refused.
- R7: The byte after an accepted general call pulses `gc_valid`, with `rx_byte` holding the byte and `gc_kind` decoded as follows: 0 for 0x06 (reset and load), 1 for 0x04 (load only), 2 for any byte whose bit 0 is 1 (hardware call), and 3 for anything else.
- R8: In a write transfer, each data byte pulses `rx_valid` with `rx_byte`. It is acknowledged when `rx_accept` is 1. When `rx_accept` is 0 the byte is refused with no pulse, and the rest of the transfer is ignored.
- R9: If `local_ready` is 0 when the eighth bit of a byte this device handles ends, `scl_hold` keeps the clock low until `local_ready` is 1. The acknowledge or refusal is placed on data at least one cycle before the clock is released.
- R10: `sda_pull` changes only while the bus clock is low.
- R11: In a read transfer, `tx_byte` is sent MSB first and `tx_taken` pulses each time a byte is loaded. After a master acknowledge the next byte follows. After a master refusal the data line is released until stop or repeated start.
- R12: A stop or repeated start in the middle of a byte returns the decoder to waiting for an address and drops any half-finished 10-bit match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| own_addr7 | input | 7 | Own 7-bit address |
| own_addr10 | input | 10 | Own 10-bit address |
| en_7bit | input | 1 | Enable 7-bit matching |
| en_10bit | input | 1 | Enable 10-bit matching |
| gc_enable | input | 1 | Enable general-call reception |
| local_ready | input | 1 | Local side can take the current byte now |
| rx_accept | input | 1 | Local side accepts further written bytes |
| tx_byte | input | 8 | Next byte to send in a read |
| scl_hold | output | 1 | Pull the bus clock low |
| sda_pull | output | 1 | Pull the bus data low |
| hit_valid | output | 1 | Address match pulse |
| hit_kind | output | 2 | 1 seven-bit, 2 ten-bit, 3 general call |
| hit_rw | output | 1 | Direction of the match, 1 = read |
| gc_valid | output | 1 | General-call command pulse |
| gc_kind | output | 2 | Decoded general-call command |
| rx_valid | output | 1 | Written data byte pulse |
| rx_byte | output | 8 | Received data or command byte |
| tx_taken | output | 1 | Transmit byte loaded |

## Verification
The assertions check on every cycle that the data line moves only while the clock is low and that a stretched clock is released only after the answer is already on the data line. They also check that nothing is driven while the decoder sits idle, that no more than one report pulses at a time, and that a general-call match never happens unless reception was enabled. The bench scenarios are the only way to show the decode results: which address bytes are acknowledged, the reported kind and direction, the command decode, the 10-bit read rule across a stop, the transmit order, and how a mid-byte start or stop resets the decoder.

// File: rtl/i2c_adec_pkg.sv
package i2c_adec_pkg;

    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);

    localparam logic [4:0] TENBIT_PREFIX = 5'b11110;
    localparam logic [7:0] GC_CODE_RESET = 8'h06;
    localparam logic [7:0] GC_CODE_LOAD  = 8'h04;

    typedef enum logic [1:0] {
        ROLE_ADDR,
        ROLE_ADDR10LO,
        ROLE_GCCMD,
        ROLE_DATA
    } role_e;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_7BIT  = 2'd1,
        HIT_10BIT = 2'd2,
        HIT_GCALL = 2'd3
    } hit_e;

    typedef enum logic [1:0] {
        GC_RESET_LOAD = 2'd0,
        GC_LOAD_ONLY  = 2'd1,
        GC_HARDWARE   = 2'd2,
        GC_OTHER      = 2'd3
    } gccmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_STRETCH,
        ST_RELEASE,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } state_e;

    typedef struct packed {
        logic  ack;
        logic  report_hit;
        hit_e  hit;
        logic  rw;
        logic  go_tx;
        role_e next_role;
        logic  ten_full_set;
        logic  is_gccmd;
        logic  is_data;
    } verdict_t;

    function automatic gccmd_e gc_classify(input logic [7:0] b);
        if (b[0])                    return GC_HARDWARE;
        else if (b == GC_CODE_RESET) return GC_RESET_LOAD;
        else if (b == GC_CODE_LOAD)  return GC_LOAD_ONLY;
        else                         return GC_OTHER;
    endfunction

endpackage

// File: rtl/i2c_adec_bus.sv
module i2c_adec_bus #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_seen,
    output logic stop_seen
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_prev;
    logic                   sda_prev;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync[0] <= scl_in;
                    sda_sync[0] <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
                    sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_lvl;
            sda_prev <= sda_lvl;
        end
    end

    assign scl_lvl    = scl_sync[SYNC_STAGES-1];
    assign sda_lvl    = sda_sync[SYNC_STAGES-1];
    assign scl_rise   = scl_lvl & ~scl_prev;
    assign scl_fall   = ~scl_lvl & scl_prev;
    assign start_seen = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_seen  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_adec_match.sv
module i2c_adec_match
    import i2c_adec_pkg::*;
(
    input  logic [7:0] byte_in,
    input  role_e      role,
    input  logic [6:0] own_addr7,
    input  logic [9:0] own_addr10,
    input  logic       en_7bit,
    input  logic       en_10bit,
    input  logic       gc_enable,
    input  logic       ten_full,
    input  logic       rx_accept,
    output verdict_t   v
);
    always_comb begin
        v           = '0;
        v.hit       = HIT_NONE;
        v.next_role = ROLE_DATA;
        unique case (role)
            ROLE_ADDR: begin
                if (byte_in[7:3] == TENBIT_PREFIX) begin
                    if (en_10bit && byte_in[2:1] == own_addr10[9:8]) begin
                        if (!byte_in[0]) begin
                            v.ack       = 1'b1;
                            v.next_role = ROLE_ADDR10LO;
                        end else if (ten_full) begin
                            v.ack        = 1'b1;
                            v.report_hit = 1'b1;
                            v.hit        = HIT_10BIT;
                            v.rw         = 1'b1;
                            v.go_tx      = 1'b1;
                        end
                    end
                end else if (byte_in[7:1] == 7'd0) begin
                    if (!byte_in[0] && gc_enable) begin
                        v.ack        = 1'b1;
                        v.report_hit = 1'b1;
                        v.hit        = HIT_GCALL;
                        v.next_role  = ROLE_GCCMD;
                    end
                end else if (en_7bit && byte_in[7:1] == own_addr7) begin
                    v.ack        = 1'b1;
                    v.report_hit = 1'b1;
                    v.hit        = HIT_7BIT;
                    v.rw         = byte_in[0];
                    v.go_tx      = byte_in[0];
                end
            end
            ROLE_ADDR10LO: begin
                if (byte_in == own_addr10[7:0]) begin
                    v.ack          = 1'b1;
                    v.report_hit   = 1'b1;
                    v.hit          = HIT_10BIT;
                    v.ten_full_set = 1'b1;
                end
            end
            ROLE_GCCMD: begin
                v.ack      = rx_accept;
                v.is_gccmd = 1'b1;
            end
            default: begin
                v.ack     = rx_accept;
                v.is_data = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/i2c_adec_ctrl.sv
module i2c_adec_ctrl
    import i2c_adec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_lvl,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_seen,
    input  logic       stop_seen,
    input  logic       local_ready,
    input  logic [7:0] tx_byte,
    input  verdict_t   v,
    output logic [7:0] shreg,
    output role_e      role,
    output logic       ten_full,
    output logic       scl_hold,
    output logic       sda_pull,
    output logic       hit_valid,
    output hit_e       hit_kind,
    output logic       hit_rw,
    output logic       gc_valid,
    output gccmd_e     gc_kind,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       tx_taken
);
    state_e           state;
    logic [CNT_W-1:0] cnt;
    logic             ack_q;
    logic             go_tx_q;
    role_e            next_role_q;
    logic             mack;

    logic byte_full, may_stretch, at_slot, decide;

    always_comb begin
        byte_full   = (cnt == CNT_FULL);
        may_stretch = (role == ROLE_GCCMD) || (role == ROLE_DATA) || v.ack;
        at_slot     = (state == ST_RX) && scl_fall && byte_full;
        decide      = (at_slot && !(may_stretch && !local_ready)) ||
                      ((state == ST_STRETCH) && local_ready);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            role        <= ROLE_ADDR;
            cnt         <= '0;
            shreg       <= '0;
            ten_full    <= 1'b0;
            ack_q       <= 1'b0;
            go_tx_q     <= 1'b0;
            next_role_q <= ROLE_ADDR;
            mack        <= 1'b0;
            scl_hold    <= 1'b0;
            sda_pull    <= 1'b0;
            hit_valid   <= 1'b0;
            hit_kind    <= HIT_NONE;
            hit_rw      <= 1'b0;
            gc_valid    <= 1'b0;
            gc_kind     <= GC_OTHER;
            rx_valid    <= 1'b0;
            rx_byte     <= '0;
            tx_taken    <= 1'b0;
        end else begin
            hit_valid <= 1'b0;
            gc_valid  <= 1'b0;
            rx_valid  <= 1'b0;
            tx_taken  <= 1'b0;
            if (stop_seen) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                scl_hold <= 1'b0;
                ten_full <= 1'b0;
            end else if (start_seen) begin
                state    <= ST_RX;
                role     <= ROLE_ADDR;
                cnt      <= '0;
                sda_pull <= 1'b0;
                scl_hold <= 1'b0;
            end else if (decide) begin
                sda_pull    <= v.ack;
                ack_q       <= v.ack;
                go_tx_q     <= v.go_tx;
                next_role_q <= v.next_role;
                scl_hold    <= (state == ST_STRETCH);
                if (state == ST_STRETCH) state <= ST_RELEASE;
                else                     state <= v.ack ? ST_ACK : ST_IDLE;
                if (v.ack) begin
                    hit_valid <= v.report_hit;
                    hit_kind  <= v.hit;
                    hit_rw    <= v.rw;
                    gc_valid  <= v.is_gccmd;
                    gc_kind   <= gc_classify(shreg);
                    rx_valid  <= v.is_data;
                    rx_byte   <= shreg;
                end
                if (role == ROLE_ADDR && !(v.ack && v.hit == HIT_10BIT))
                    ten_full <= 1'b0;
                if (v.ack && v.ten_full_set)
                    ten_full <= 1'b1;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (scl_rise && !byte_full) begin
                            shreg <= {shreg[6:0], sda_lvl};
                            cnt   <= cnt + 1'b1;
                        end else if (at_slot) begin
                            state    <= ST_STRETCH;
                            scl_hold <= 1'b1;
                        end
                    end
                    ST_RELEASE: begin
                        scl_hold <= 1'b0;
                        state    <= ack_q ? ST_ACK : ST_IDLE;
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (go_tx_q) begin
                                shreg    <= tx_byte;
                                sda_pull <= ~tx_byte[7];
                                tx_taken <= 1'b1;
                                state    <= ST_TX;
                            end else begin
                                sda_pull <= 1'b0;
                                role     <= next_role_q;
                                state    <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == CNT_LAST) begin
                                sda_pull <= 1'b0;
                                state    <= ST_TXACK;
                            end else begin
                                shreg    <= {shreg[6:0], 1'b0};
                                sda_pull <= ~shreg[6];
                                cnt      <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) mack <= ~sda_lvl;
                        if (scl_fall) begin
                            cnt <= '0;
                            if (mack) begin
                                shreg    <= tx_byte;
                                sda_pull <= ~tx_byte[7];
                                tx_taken <= 1'b1;
                                state    <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: the data line only moves while the clock is low
    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> !scl_lvl);

    // R9: a stretched clock is freed only after the acknowledge is on the data line
    a_r9_ack_before_release: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_hold) && ack_q) |-> $past(sda_pull));

    // R3: an idle decoder drives neither line
    a_r3_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> (!sda_pull && !scl_hold));

    // R2: at most one report per cycle
    a_r2_one_report: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit_valid, gc_valid, rx_valid}));

endmodule

// File: rtl/i2c_addr_decoder.sv
module i2c_addr_decoder
    import i2c_adec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [6:0] own_addr7,
    input  logic [9:0] own_addr10,
    input  logic       en_7bit,
    input  logic       en_10bit,
    input  logic       gc_enable,
    input  logic       local_ready,
    input  logic       rx_accept,
    input  logic [7:0] tx_byte,
    output logic       scl_hold,
    output logic       sda_pull,
    output logic       hit_valid,
    output logic [1:0] hit_kind,
    output logic       hit_rw,
    output logic       gc_valid,
    output logic [1:0] gc_kind,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       tx_taken
);
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_seen, stop_seen;
    logic [7:0] shreg;
    role_e      role;
    logic       ten_full;
    verdict_t   verdict;
    hit_e       hit_kind_e;
    gccmd_e     gc_kind_e;

    i2c_adec_bus #(.SYNC_STAGES(SYNC_STAGES)) u_bus (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .scl_lvl    (scl_lvl),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    i2c_adec_match u_match (
        .byte_in    (shreg),
        .role       (role),
        .own_addr7  (own_addr7),
        .own_addr10 (own_addr10),
        .en_7bit    (en_7bit),
        .en_10bit   (en_10bit),
        .gc_enable  (gc_enable),
        .ten_full   (ten_full),
        .rx_accept  (rx_accept),
        .v          (verdict)
    );

    i2c_adec_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .scl_lvl     (scl_lvl),
        .sda_lvl     (sda_lvl),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_seen  (start_seen),
        .stop_seen   (stop_seen),
        .local_ready (local_ready),
        .tx_byte     (tx_byte),
        .v           (verdict),
        .shreg       (shreg),
        .role        (role),
        .ten_full    (ten_full),
        .scl_hold    (scl_hold),
        .sda_pull    (sda_pull),
        .hit_valid   (hit_valid),
        .hit_kind    (hit_kind_e),
        .hit_rw      (hit_rw),
        .gc_valid    (gc_valid),
        .gc_kind     (gc_kind_e),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .tx_taken    (tx_taken)
    );

    assign hit_kind = hit_kind_e;
    assign gc_kind  = gc_kind_e;

    // R6: a general-call match requires reception to be enabled
    a_r6_gc_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && hit_kind == HIT_GCALL) |-> $past(gc_enable));

endmodule

// File: tb/tb_i2c_addr_decoder.sv
module tb_i2c_addr_decoder;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [6:0] own_addr7 = 7'h3A;
    logic [9:0] own_addr10 = 10'h2A5;
    logic en_7bit = 1'b1, en_10bit = 1'b1, gc_enable = 1'b0;
    logic local_ready = 1'b1, rx_accept = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic scl_hold, sda_pull, hit_valid, hit_rw, gc_valid, rx_valid, tx_taken;
    logic [1:0] hit_kind, gc_kind;
    logic [7:0] rx_byte;
    logic scl_bus, sda_bus;

    int vectors = 0, fails = 0;
    int n_hit = 0, n_gc = 0, n_rx = 0, n_tx = 0, r10_bad = 0;
    logic [1:0] l_kind = 0, l_gck = 0;
    logic l_rw = 0, prev_pull = 0;
    logic [7:0] l_byte = 0;

    always #10 clk = ~clk;

    assign scl_bus = scl_m & ~scl_hold;
    assign sda_bus = sda_m & ~sda_pull;

    i2c_addr_decoder dut (
        .clk(clk), .rst(rst), .scl_in(scl_bus), .sda_in(sda_bus),
        .own_addr7(own_addr7), .own_addr10(own_addr10),
        .en_7bit(en_7bit), .en_10bit(en_10bit), .gc_enable(gc_enable),
        .local_ready(local_ready), .rx_accept(rx_accept), .tx_byte(tx_byte),
        .scl_hold(scl_hold), .sda_pull(sda_pull), .hit_valid(hit_valid),
        .hit_kind(hit_kind), .hit_rw(hit_rw), .gc_valid(gc_valid),
        .gc_kind(gc_kind), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_taken(tx_taken)
    );

    always @(posedge clk) begin
        if (hit_valid) begin n_hit <= n_hit + 1; l_kind <= hit_kind; l_rw <= hit_rw; end
        if (gc_valid)  begin n_gc <= n_gc + 1; l_gck <= gc_kind; l_byte <= rx_byte; end
        if (rx_valid)  begin n_rx <= n_rx + 1; l_byte <= rx_byte; end
        if (tx_taken)  n_tx <= n_tx + 1;
        if (!rst && sda_pull != prev_pull && scl_bus) r10_bad <= r10_bad + 1;
        prev_pull <= sda_pull;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bit_cycle(input logic b, output logic s, output int waited);
        tick(Q); sda_m = b; tick(Q); scl_m = 1'b1;
        waited = 0;
        while (!scl_bus) begin tick(1); waited++; end
        tick(Q); s = sda_bus; tick(Q); scl_m = 1'b0;
    endtask

    task automatic send_start();
        sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl_m = 1'b0;
    endtask

    task automatic send_stop();
        tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s; int w;
        for (int i = 7; i > 7 - n; i--) bit_cycle(b[i], s, w);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack, output int waited);
        logic s; int w;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s, w);
        bit_cycle(1'b1, s, waited);
        ack = !s;
    endtask

    task automatic read_byte(input logic master_ack, output logic [7:0] b);
        logic s; int w;
        for (int i = 7; i >= 0; i--) begin bit_cycle(1'b1, s, w); b[i] = s; end
        bit_cycle(!master_ack, s, w);
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(4);
        chk("R1 hold in reset", {scl_hold, sda_pull}, 2'b00);
        rst = 1'b0; tick(4);
        chk("R1 after reset", {scl_hold, sda_pull, hit_valid, gc_valid, rx_valid, tx_taken}, 6'd0);
    endtask

    task automatic t_seven_write();
        logic a; int w; int h0 = n_hit, r0 = n_rx;
        send_start();
        write_byte(8'h74, a, w); chk("R2 ack 7-bit write", a, 1);
        chk("R2 one report", n_hit - h0, 1); chk("R2 kind", l_kind, 1); chk("R2 rw", l_rw, 0);
        chk("R9 no stretch when ready", w < 5, 1);
        write_byte(8'hC5, a, w); chk("R8 data ack", a, 1);
        chk("R8 rx pulse", n_rx - r0, 1); chk("R8 rx byte", l_byte, 8'hC5);
        send_stop();
    endtask

    task automatic t_seven_read();
        logic a; int w; logic [7:0] b; int t0 = n_tx;
        tx_byte = 8'h96;
        send_start();
        write_byte(8'h75, a, w); chk("R2 ack 7-bit read", a, 1); chk("R2 rw read", l_rw, 1);
        tick(4); tx_byte = 8'h3C;
        read_byte(1'b1, b); chk("R11 first byte", b, 8'h96);
        read_byte(1'b0, b); chk("R11 second byte", b, 8'h3C);
        chk("R11 loads", n_tx - t0, 2);
        tick(3 * Q); chk("R11 released after master nack", sda_bus, 1);
        send_stop();
    endtask

    task automatic t_mismatch();
        logic a; int w; int h0 = n_hit;
        send_start();
        write_byte(8'h44, a, w); chk("R3 nack foreign address", a, 0);
        write_byte(8'h74, a, w); chk("R3 ignored until start", a, 0);
        chk("R3 no report", n_hit - h0, 0);
        send_stop();
        send_start();
        write_byte(8'h01, a, w); chk("R6 zero with read bit refused", a, 0);
        send_stop();
    endtask

    task automatic t_ten_bit();
        logic a; int w; logic [7:0] b; int h0 = n_hit;
        tx_byte = 8'h5E;
        send_start();
        write_byte(8'hF4, a, w); chk("R4 prefix ack", a, 1); chk("R4 no early report", n_hit - h0, 0);
        write_byte(8'hA5, a, w); chk("R4 low byte ack", a, 1);
        chk("R4 kind", l_kind, 2); chk("R4 rw", l_rw, 0);
        send_start();
        write_byte(8'hF5, a, w); chk("R5 read after match", a, 1);
        chk("R5 kind", l_kind, 2); chk("R5 rw", l_rw, 1);
        read_byte(1'b0, b); chk("R11 ten-bit read data", b, 8'h5E);
        send_stop();
        send_start();
        write_byte(8'hF5, a, w); chk("R5 refused after stop", a, 0);
        send_stop();
        send_start();
        write_byte(8'hF4, a, w); chk("R4 prefix ack again", a, 1);
        write_byte(8'hA6, a, w); chk("R4 wrong low byte", a, 0);
        send_stop();
        send_start();
        write_byte(8'hF2, a, w); chk("R4 wrong top bits", a, 0);
        send_stop();
    endtask

    task automatic gc_one(input logic [7:0] cmd, input logic [1:0] exp_kind, input string tag);
        logic a; int w; int g0 = n_gc;
        send_start();
        write_byte(8'h00, a, w); chk("R6 general call ack", a, 1); chk("R6 kind", l_kind, 3);
        write_byte(cmd, a, w); chk("R7 command ack", a, 1);
        chk("R7 pulse", n_gc - g0, 1); chk(tag, l_gck, exp_kind); chk("R7 byte", l_byte, cmd);
        send_stop();
    endtask

    task automatic t_general_call();
        logic a; int w; int h0 = n_hit;
        gc_enable = 1'b0;
        send_start();
        write_byte(8'h00, a, w); chk("R6 disabled refused", a, 0); chk("R6 no report", n_hit - h0, 0);
        send_stop();
        gc_enable = 1'b1;
        gc_one(8'h06, 2'd0, "R7 reset-load");
        gc_one(8'h04, 2'd1, "R7 load only");
        gc_one(8'h75, 2'd2, "R7 hardware call");
        gc_one(8'h10, 2'd3, "R7 other");
        gc_enable = 1'b0;
    endtask

    task automatic t_data_refuse();
        logic a; int w; int r0 = n_rx;
        send_start();
        write_byte(8'h74, a, w); chk("R8 address ack", a, 1);
        rx_accept = 1'b0;
        write_byte(8'h11, a, w); chk("R8 refused data", a, 0);
        rx_accept = 1'b1;
        write_byte(8'h22, a, w); chk("R8 rest ignored", a, 0);
        chk("R8 no rx pulse", n_rx - r0, 0);
        send_stop();
    endtask

    task automatic t_stretch();
        logic a; int w;
        local_ready = 1'b0;
        fork begin tick(300); local_ready = 1'b1; end join_none
        send_start();
        write_byte(8'h74, a, w);
        chk("R9 clock held", w > 100, 1); chk("R9 ack after stretch", a, 1);
        local_ready = 1'b0; rx_accept = 1'b0;
        fork begin tick(300); local_ready = 1'b1; end join_none
        write_byte(8'h33, a, w);
        chk("R9 held before refusal", w > 100, 1); chk("R9 refusal after stretch", a, 0);
        rx_accept = 1'b1;
        send_stop();
    endtask

    task automatic t_midbyte();
        logic a; int w;
        send_start(); send_bits(8'h74, 4); send_stop();
        send_start();
        write_byte(8'h74, a, w); chk("R12 ack after mid-byte stop", a, 1);
        send_stop();
        send_start(); send_bits(8'h74, 3);
        send_start();
        write_byte(8'h74, a, w); chk("R12 ack after mid-byte restart", a, 1);
        send_stop();
        send_start();
        write_byte(8'hF4, a, w); chk("R12 prefix ack", a, 1);
        send_start();
        write_byte(8'hA5, a, w); chk("R12 partial match dropped", a, 0);
        send_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_seven_write();
        t_seven_read();
        t_mismatch();
        t_ten_bit();
        t_general_call();
        t_data_refuse();
        t_stretch();
        t_midbyte();
        chk("R10 data moved only with clock low", r10_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule